// File: doc/BRIEF.md
# Four-Mode Timer/Event Counter Channel

This block is one channel of a timer/event counter. It keeps its count in a pair of byte registers and advances the count either once per machine cycle, which is six input clocks, or once per falling edge seen on an external count pin. It runs only while its enable is high. A 2-bit mode input chooses how the two bytes are wired together: a prescaled count, a full 16-bit count, an 8-bit count with auto-reload, or two independent 8-bit counters. Each byte can be loaded at any time through its own write strobe.

The external pin is sampled once per machine cycle. A count event is produced when one sample is high and the following sample is low. Overflows raise sticky flags, which an interrupt controller can watch. Each flag stays set until its clear input is pulsed.

Top module: `tcnt_channel`

## Requirements
- R1: With `run` high and `ext_sel` low, the count advances exactly once per machine cycle of 6 clocks. Over 6·N clocks it advances N times.
- R2: With `ext_sel` high, the count advances once for each high-to-low change of `ext_pin`, and machine-cycle ticks alone do not advance it. Each level must last at least one machine cycle. The count is applied within two machine cycles of the low level. Events arrive at most once per two machine cycles.
- R3: While `run` is low, the count does not change, even if `ext_pin` toggles.
- R4: `mode` = 2'b00 works as a prescaled count. Bits [4:0] of `count_lo` form a divide-by-32 stage, and bits [7:5] of `count_lo` stay unchanged. The stage carries into `count_hi`. `ovf_flag` sets when `count_hi` wraps from 0xFF.
- R5: `mode` = 2'b01 is a 16-bit count {`count_hi`,`count_lo`}. `ovf_flag` sets on the wrap from 0xFFFF to 0x0000.
- R6: `mode` = 2'b10 counts in `count_lo` only. When `count_lo` passes 0xFF it reloads from `count_hi` and `ovf_flag` sets. `count_hi` is unchanged.
- R7: `mode` = 2'b11 splits the bytes. `count_lo` counts under `run`/`ext_sel` and sets `ovf_flag` when it wraps. `count_hi` counts machine cycles only while `hi_run` is high, and sets `ovf2_flag` when it wraps. `hi_run` has no effect in any other mode.
- R8: Both flags stay set until `flag_clr` or `flag2_clr` is pulsed. If a flag is set and cleared in the same cycle, setting wins.
- R9: Reset clears both bytes and both flags. `lo_wr`/`hi_wr` load `wr_data` into the selected byte on the next clock, and a write takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Count enable for the main count |
| ext_sel | input | 1 | 1 = count pin edges, 0 = count machine cycles |
| mode | input | 2 | Count structure select |
| ext_pin | input | 1 | External event input |
| hi_run | input | 1 | Enable for the high byte in split mode |
| lo_wr | input | 1 | Load `wr_data` into the low byte |
| hi_wr | input | 1 | Load `wr_data` into the high byte |
| wr_data | input | 8 | Byte write data |
| flag_clr | input | 1 | Clear `ovf_flag` |
| flag2_clr | input | 1 | Clear `ovf2_flag` |
| count_lo | output | 8 | Low byte of the count |
| count_hi | output | 8 | High byte of the count |
| ovf_flag | output | 1 | Sticky overflow flag of the main count |
| ovf2_flag | output | 1 | Sticky overflow flag of the split high byte |

## Verification
A machine-cycle phase that is off by one shows up at the ports as a count that is wrong after N machine cycles, and the error grows with N. A faulty edge sampler gives a count of events that is too high or too low, visible two machine cycles after the last edge. Wrong wiring between the bytes in a mode shows up at the next carry or reload: a wrong byte value or a missing flag. Preloads placed just below each wrap point make that carry or reload happen within a few machine cycles.

// File: rtl/tcnt_channel.sv
module tcnt_channel #(
  parameter int CYC_CLKS = 6,
  parameter int PRE_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ext_sel,
  input  logic [1:0] mode,
  input  logic       ext_pin,
  input  logic       hi_run,
  input  logic       lo_wr,
  input  logic       hi_wr,
  input  logic [7:0] wr_data,
  input  logic       flag_clr,
  input  logic       flag2_clr,
  output logic [7:0] count_lo,
  output logic [7:0] count_hi,
  output logic       ovf_flag,
  output logic       ovf2_flag
);
  localparam int PW = $clog2(CYC_CLKS);
  localparam logic [PW-1:0] PH_LAST = PW'(CYC_CLKS - 1);
  localparam logic [PW-1:0] PH_ONE = PW'(1);
  localparam logic [PRE_BITS-1:0] PRE_ONE = PRE_BITS'(1);

  logic [PW-1:0] phase;
  logic          tick, smp_new, smp_old, cnt_evt, inc_lo, inc_hi;
  logic [7:0]    lo_n, hi_n;
  logic          set1, set2;

  assign tick    = (phase == PH_LAST);
  assign cnt_evt = tick & smp_old & ~smp_new;
  assign inc_lo  = run & (ext_sel ? cnt_evt : tick);
  assign inc_hi  = hi_run & tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      smp_new <= 1'b1;
      smp_old <= 1'b1;
    end else begin
      phase <= tick ? '0 : phase + PH_ONE;
      if (tick) begin
        smp_new <= ext_pin;
        smp_old <= smp_new;
      end
    end
  end

  always_comb begin
    lo_n = count_lo;
    hi_n = count_hi;
    set1 = 1'b0;
    set2 = 1'b0;
    case (mode)
      2'd0: if (inc_lo) begin
        lo_n[PRE_BITS-1:0] = count_lo[PRE_BITS-1:0] + PRE_ONE;
        if (&count_lo[PRE_BITS-1:0]) begin
          hi_n = count_hi + 8'd1;
          set1 = &count_hi;
        end
      end
      2'd1: if (inc_lo) begin
        {hi_n, lo_n} = {count_hi, count_lo} + 16'd1;
        set1 = &{count_hi, count_lo};
      end
      2'd2: if (inc_lo) begin
        if (&count_lo) begin
          lo_n = count_hi;
          set1 = 1'b1;
        end else begin
          lo_n = count_lo + 8'd1;
        end
      end
      default: begin
        if (inc_lo) begin
          lo_n = count_lo + 8'd1;
          set1 = &count_lo;
        end
        if (inc_hi) begin
          hi_n = count_hi + 8'd1;
          set2 = &count_hi;
        end
      end
    endcase
    if (lo_wr) lo_n = wr_data;
    if (hi_wr) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_lo  <= '0;
      count_hi  <= '0;
      ovf_flag  <= 1'b0;
      ovf2_flag <= 1'b0;
    end else begin
      count_lo  <= lo_n;
      count_hi  <= hi_n;
      ovf_flag  <= set1 | (ovf_flag & ~flag_clr);
      ovf2_flag <= set2 | (ovf2_flag & ~flag2_clr);
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R1
  AST_EVENT_SPACING: assert property (@(posedge clk) disable iff (!rst_n) cnt_evt |=> !cnt_evt); // R2
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hi_run && !lo_wr && !hi_wr) |=> $stable(count_lo) && $stable(count_hi)); // R3
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && inc_lo && count_lo == 8'hFF && !lo_wr) |=> count_lo == $past(count_hi)); // R6
  AST_HI_STILL_M2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !hi_wr) |=> $stable(count_hi)); // R6
  AST_FLAG2_SPLIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf2_flag) |-> $past(mode) == 2'd3); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R8
endmodule

// File: tb/tcnt_channel_bench.sv
`timescale 1ns/1ps
module tcnt_channel_bench;
  logic clk = 0, rst_n = 0, run = 0, ext_sel = 0, ext_pin = 1, hi_run = 0;
  logic lo_wr = 0, hi_wr = 0, flag_clr = 0, flag2_clr = 0;
  logic [1:0] mode = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] count_lo, count_hi;
  logic ovf_flag, ovf2_flag;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcnt_channel u_tcnt_channel (.*);

  // mode, lo, hi, machine cycles, expected lo, expected hi, expected flag
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 8'hFE, 8'h12, 8'd3, 8'h01, 8'h13, 1'b0},
    {2'd1, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 1'b1},
    {2'd0, 8'h1E, 8'h05, 8'd3, 8'h01, 8'h06, 1'b0},
    {2'd0, 8'hFF, 8'h10, 8'd2, 8'hE1, 8'h11, 1'b0},
    {2'd0, 8'h1F, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},
    {2'd2, 8'hFD, 8'h80, 8'd4, 8'h81, 8'h80, 1'b1},
    {2'd2, 8'h10, 8'h80, 8'd5, 8'h15, 8'h80, 1'b0},
    {2'd3, 8'hFF, 8'h33, 8'd1, 8'h00, 8'h33, 1'b1}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit hi, logic [7:0] v);
    @(negedge clk);
    wr_data = v; lo_wr = !hi; hi_wr = hi;
    @(negedge clk);
    lo_wr = 0; hi_wr = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 1; flag2_clr = 1;
    @(negedge clk); flag_clr = 0; flag2_clr = 0;
  endtask

  task automatic run_mc(int n);
    @(negedge clk); run = 1;
    repeat (6 * n) @(posedge clk);
    @(negedge clk); run = 0;
  endtask

  function automatic string tag_of(logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset lo", count_lo, 8'h00);
    check("R9 reset hi", count_hi, 8'h00);
    check("R9 reset flags", {6'd0, ovf2_flag, ovf_flag}, 8'h00);

    wr(0, 8'hA5);
    check("R9 write lo", count_lo, 8'hA5);
    wr(1, 8'h5A);
    check("R9 write hi", count_hi, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][42:41];
      clr_flags();
      wr(0, VEC[i][40:33]);
      wr(1, VEC[i][32:25]);
      run_mc(int'(VEC[i][24:17]));
      repeat (12) @(negedge clk);
      check({tag_of(mode), " R1 lo"}, count_lo, VEC[i][16:9]);
      check({tag_of(mode), " R1 hi"}, count_hi, VEC[i][8:1]);
      check({tag_of(mode), " flag"}, {7'd0, ovf_flag}, {7'd0, VEC[i][0]});
    end

    // R8: flag remains after further counting, then clears
    run_mc(2);
    check("R8 sticky", {7'd0, ovf_flag}, 8'd1);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R8 cleared", {7'd0, ovf_flag}, 8'd0);

    // R7: split high byte counts on hi_run regardless of ext_sel/run
    mode = 2'd3; ext_sel = 1;
    wr(0, 8'h40); wr(1, 8'hFE);
    @(negedge clk); hi_run = 1;
    repeat (18) @(posedge clk);
    @(negedge clk); hi_run = 0;
    check("R7 split hi", count_hi, 8'h01);
    check("R7 split lo held", count_lo, 8'h40);
    check("R7 flag2", {6'd0, ovf2_flag, ovf_flag}, 8'h02);
    @(negedge clk); flag2_clr = 1; @(negedge clk); flag2_clr = 0;
    check("R8 flag2 cleared", {7'd0, ovf2_flag}, 8'd0);

    // R7: hi_run ignored outside split mode
    mode = 2'd2;
    wr(1, 8'h22);
    @(negedge clk); hi_run = 1;
    repeat (18) @(posedge clk);
    @(negedge clk); hi_run = 0;
    check("R7 hi_run ignored", count_hi, 8'h22);

    // R2: counter mode, slow edges
    mode = 2'd1; ext_sel = 1; ext_pin = 1;
    wr(0, 8'h00); wr(1, 8'h00);
    @(negedge clk); run = 1;
    repeat (12) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      ext_pin = 0; repeat (12) @(negedge clk);
      ext_pin = 1; repeat (12) @(negedge clk);
    end
    repeat (18) @(negedge clk);
    run = 0;
    @(negedge clk);
    check("R2 slow edges", count_lo, 8'd5);

    // R3: pin activity with run low
    for (int k = 0; k < 3; k++) begin
      ext_pin = 0; repeat (12) @(negedge clk);
      ext_pin = 1; repeat (12) @(negedge clk);
    end
    check("R3 held lo", count_lo, 8'd5);
    check("R3 held hi", count_hi, 8'd0);

    // R2: fastest legal rate, one machine cycle per level
    wr(0, 8'h00);
    repeat (12) @(negedge clk);
    @(negedge clk); run = 1;
    repeat (12) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      ext_pin = 0; repeat (6) @(negedge clk);
      ext_pin = 1; repeat (6) @(negedge clk);
    end
    repeat (18) @(negedge clk);
    run = 0;
    @(negedge clk);
    check("R2 max rate", count_lo, 8'd4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule